// File: doc/BRIEF.md
# Framing Loss and Carrier Loss Resync Monitor

This block sits beside a receive framer that already holds alignment. It decides when the framer must start a fresh alignment search. It keeps a short history of framing-bit errors and raises an out-of-frame flag when too many of the most recent framing bits are wrong. It also counts bit periods in which neither line rail carries a mark, and raises a carrier-loss flag when that run grows long enough. Either flag can start a resync automatically. An enable bit can block this automatic path. A software request edge and a release edge on an active-low external pin always start a resync.

Every clock cycle is one received bit period. A framing-bit strobe marks the cycles that carry a framing bit. On those cycles the received framing bit is compared against the value the framer expects. The framer reports when it adopts a new alignment, and this clears the error history. While the external pin is low, a hold output keeps the downstream receive timing in reset. The external pin is taken as already synchronous to the clock.

A three-state controller produces the resync pulse and the timing hold:
- `ST_RUN` is normal monitoring.
- `ST_FIRE` lasts one cycle and drives the resync pulse.
- `ST_HOLD` follows the external pin while it is low.

The controller makes these transitions:
- `ST_RUN` to `ST_HOLD` when the pin is low.
- `ST_RUN` to `ST_FIRE` on any trigger edge.
- `ST_FIRE` to `ST_HOLD` when the pin is low, and otherwise `ST_FIRE` to `ST_RUN`.
- `ST_HOLD` to `ST_FIRE` when the pin returns high.

A trigger edge that arrives during `ST_FIRE` merges into the pulse already under way.

Top module: `frame_loss_monitor`

## Requirements
- R1: The out-of-frame flag is high whenever at least 2 of the last 4 strobed framing bits were in error. An error is a received bit that differs from the expected bit. The flag changes in the cycle after the clock edge that samples the strobe.
- R2: The error history advances only on strobed cycles. A mismatch in a cycle without the strobe has no effect on the flag. The window slides, so an error older than 4 strobes no longer counts.
- R3: A new-alignment indication clears the error history. The out-of-frame flag is low in the next cycle.
- R4: The carrier-loss flag rises after 32 consecutive sampled cycles in which both rails are 0. After 31 such cycles it is still low.
- R5: The zero-run count saturates, so the carrier-loss flag stays high while the zero run continues. A 1 on either rail clears the count, and the flag is low in the next cycle.
- R6: With automatic resync enabled (disable bit = 0), the rise of out-of-frame or carrier-loss gives a resync pulse. The pulse comes in the cycle after the flag first shows.
- R7: The resync output is a single-cycle pulse. A condition that stays true gives no further pulse.
- R8: With the disable bit = 1, out-of-frame and carrier loss give no resync pulse, while both flags still report.
- R9: A 0-to-1 transition of the software request gives one resync pulse in the cycle after it is sampled, whatever the disable bit is. Holding the request high gives no more pulses.
- R10: While the external pin is low, the timing-hold output is high from the next cycle on. When the pin returns high, the hold drops in the next cycle, and that same cycle carries a resync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| fbit_stb | input | 1 | Marks a framing-bit cycle |
| fbit_rx | input | 1 | Received framing bit |
| fbit_exp | input | 1 | Expected framing bit |
| align_new | input | 1 | Framer adopted a new alignment |
| rail_pos | input | 1 | Positive line rail |
| rail_neg | input | 1 | Negative line rail |
| auto_dis | input | 1 | 1 blocks the automatic resync path |
| sw_req | input | 1 | Software resync request, rising edge acts |
| ext_sync_n | input | 1 | External pin, low holds timing, rise starts resync |
| oof | output | 1 | Out-of-frame flag |
| carrier_loss | output | 1 | Carrier-loss flag |
| resync | output | 1 | Single-cycle resync trigger |
| timing_hold | output | 1 | Holds receive output timing in reset |

## Verification
The bench builds the block with its default parameters: a 4-entry history with a threshold of 2, and a 32-cycle zero run. The carrier-loss checks can therefore walk the exact 31/32 boundary and continue past it to observe saturation. The short window lets one scenario cover sliding out of an old error, ignored non-strobe mismatches, and the clear on realignment. The default depth also brings the interplay of the disable bit with the manual and pin paths within reach.

// File: rtl/flm_pkg.sv
package flm_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_FIRE = 2'd1,
        ST_HOLD = 2'd2
    } flm_state_e;

endpackage

// File: rtl/flm_err_window.sv
module flm_err_window #(
    parameter int WIN    = 4,
    parameter int ERR_TH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    input  logic bit_i,
    input  logic exp_i,
    input  logic clr_i,
    output logic oof_o
);
    localparam int CW = $clog2(WIN + 1);

    logic [WIN-1:0] hist_q;
    logic [CW-1:0]  err_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (clr_i) begin
            hist_q <= '0;
        end else if (stb_i) begin
            hist_q <= {hist_q[WIN-2:0], bit_i ^ exp_i};
        end
    end

    always_comb begin
        err_cnt = '0;
        for (int i = 0; i < WIN; i++) begin
            err_cnt = err_cnt + CW'(hist_q[i]);
        end
    end

    assign oof_o = (err_cnt >= CW'(ERR_TH));

    // R2: the flag can only rise after a strobed framing bit
    a_r2_rise_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oof_o) |-> $past(stb_i));

    // R3: realignment clears the flag
    a_r3_align_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !oof_o);

endmodule

// File: rtl/flm_zero_run.sv
module flm_zero_run #(
    parameter int ZRUN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pos_i,
    input  logic neg_i,
    output logic cl_o
);
    localparam int CW = $clog2(ZRUN + 1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (pos_i || neg_i) begin
            run_q <= '0;
        end else if (run_q != CW'(ZRUN)) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign cl_o = (run_q == CW'(ZRUN));

    // R4: the flag only rises after a cycle with both rails at zero
    a_r4_rise_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cl_o) |-> $past(!pos_i && !neg_i));

    // R5: any mark clears the flag on the next cycle
    a_r5_mark_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_i || neg_i) |=> !cl_o);

    // R5: count never passes its ceiling
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= CW'(ZRUN));

endmodule

// File: rtl/flm_resync_fsm.sv
module flm_resync_fsm
    import flm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_cond_i,
    input  logic auto_dis_i,
    input  logic sw_req_i,
    input  logic ext_n_i,
    output logic resync_o,
    output logic hold_o
);
    flm_state_e state_q, state_d;
    logic auto_q, sw_q, ext_q;
    logic auto_rise, sw_rise, ext_rise, trig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_q <= 1'b0;
            sw_q   <= 1'b0;
            ext_q  <= 1'b1;
        end else begin
            auto_q <= auto_cond_i;
            sw_q   <= sw_req_i;
            ext_q  <= ext_n_i;
        end
    end

    assign auto_rise = auto_cond_i && !auto_q;
    assign sw_rise   = sw_req_i && !sw_q;
    assign ext_rise  = ext_n_i && !ext_q;
    assign trig      = auto_rise || sw_rise || ext_rise;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (!ext_n_i)  state_d = ST_HOLD;
                else if (trig) state_d = ST_FIRE;
            end
            ST_FIRE: begin
                if (!ext_n_i) state_d = ST_HOLD;
                else          state_d = ST_RUN;
            end
            ST_HOLD: begin
                if (ext_rise) state_d = ST_FIRE;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        resync_o = (state_q == ST_FIRE);
        hold_o   = (state_q == ST_HOLD);
    end

    // R7: pulse lasts one cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resync_o |=> !resync_o);

    // R8: with auto path blocked, a pulse needs a manual or pin edge
    a_r8_blocked_auto: assert property (@(posedge clk) disable iff (!rst_n)
        (resync_o && $past(auto_dis_i)) |-> $past(sw_rise || ext_rise));

    // R10: pin low forces the timing hold on the next cycle
    a_r10_pin_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_n_i |=> hold_o);

endmodule

// File: rtl/frame_loss_monitor.sv
module frame_loss_monitor #(
    parameter int WIN    = 4,
    parameter int ERR_TH = 2,
    parameter int ZRUN   = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fbit_stb,
    input  logic fbit_rx,
    input  logic fbit_exp,
    input  logic align_new,
    input  logic rail_pos,
    input  logic rail_neg,
    input  logic auto_dis,
    input  logic sw_req,
    input  logic ext_sync_n,
    output logic oof,
    output logic carrier_loss,
    output logic resync,
    output logic timing_hold
);
    logic oof_w, cl_w, auto_cond;

    flm_err_window #(.WIN(WIN), .ERR_TH(ERR_TH)) u_err_window (
        .clk   (clk),
        .rst_n (rst_n),
        .stb_i (fbit_stb),
        .bit_i (fbit_rx),
        .exp_i (fbit_exp),
        .clr_i (align_new),
        .oof_o (oof_w)
    );

    flm_zero_run #(.ZRUN(ZRUN)) u_zero_run (
        .clk   (clk),
        .rst_n (rst_n),
        .pos_i (rail_pos),
        .neg_i (rail_neg),
        .cl_o  (cl_w)
    );

    assign auto_cond = !auto_dis && (oof_w || cl_w);

    flm_resync_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .auto_cond_i (auto_cond),
        .auto_dis_i  (auto_dis),
        .sw_req_i    (sw_req),
        .ext_n_i     (ext_sync_n),
        .resync_o    (resync),
        .hold_o      (timing_hold)
    );

    assign oof          = oof_w;
    assign carrier_loss = cl_w;

    // R6: auto path enabled, a rising flag yields a pulse next cycle
    a_r6_auto_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(oof_w || cl_w) && !auto_dis && ext_sync_n && !resync) |=> resync);

endmodule

// File: tb/frame_loss_monitor_bench.sv
`timescale 1ns/1ps
module frame_loss_monitor_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fbit_stb = 0, fbit_rx = 0, fbit_exp = 0, align_new = 0;
    logic rail_pos = 1, rail_neg = 0;
    logic auto_dis = 0, sw_req = 0, ext_sync_n = 1;
    logic oof, carrier_loss, resync, timing_hold;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    frame_loss_monitor u_frame_loss_monitor (
        .clk(clk), .rst_n(rst_n), .fbit_stb(fbit_stb), .fbit_rx(fbit_rx),
        .fbit_exp(fbit_exp), .align_new(align_new), .rail_pos(rail_pos),
        .rail_neg(rail_neg), .auto_dis(auto_dis), .sw_req(sw_req),
        .ext_sync_n(ext_sync_n), .oof(oof), .carrier_loss(carrier_loss),
        .resync(resync), .timing_hold(timing_hold)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic fstrobe(input logic err);
        fbit_stb = 1; fbit_rx = err; fbit_exp = 0;
        tick();
        fbit_stb = 0; fbit_rx = 0;
    endtask

    task automatic realign();
        align_new = 1;
        tick();
        align_new = 0;
    endtask

    task automatic t_reset();
        chk("R1 reset oof", oof, 0);
        chk("R4 reset carrier_loss", carrier_loss, 0);
        chk("R7 reset resync", resync, 0);
        chk("R10 reset timing_hold", timing_hold, 0);
    endtask

    task automatic t_oof();
        fstrobe(1); fstrobe(0); fstrobe(0); fstrobe(0);
        chk("R1 one error", oof, 0);
        fbit_rx = 1; fbit_exp = 0;
        for (int i = 0; i < 5; i++) tick();
        fbit_rx = 0;
        chk("R2 unstrobed mismatch ignored", oof, 0);
        fstrobe(1);
        chk("R2 old error slid out", oof, 0);
        chk("R6 no early pulse", resync, 0);
        fstrobe(1);
        chk("R1 two of four", oof, 1);
        chk("R6 pulse not yet", resync, 0);
        tick();
        chk("R6 pulse after oof", resync, 1);
        tick();
        chk("R7 pulse ends", resync, 0);
        for (int i = 0; i < 4; i++) tick();
        chk("R7 no repeat pulse", resync, 0);
        chk("R1 oof held", oof, 1);
        realign();
        chk("R3 realign clears oof", oof, 0);
        tick();
        chk("R3 no pulse on clear", resync, 0);
    endtask

    task automatic t_carrier();
        rail_pos = 0; rail_neg = 0;
        for (int i = 0; i < 31; i++) tick();
        chk("R4 31 zeros not enough", carrier_loss, 0);
        tick();
        chk("R4 32 zeros loss", carrier_loss, 1);
        chk("R6 pulse not yet", resync, 0);
        tick();
        chk("R6 pulse after loss", resync, 1);
        for (int i = 0; i < 10; i++) tick();
        chk("R5 saturated held", carrier_loss, 1);
        chk("R7 no repeat pulse", resync, 0);
        rail_neg = 1;
        tick();
        rail_neg = 0;
        chk("R5 mark clears", carrier_loss, 0);
        for (int i = 0; i < 31; i++) tick();
        chk("R5 count restarted", carrier_loss, 0);
        rail_pos = 1;
        tick();
    endtask

    task automatic t_disable();
        auto_dis = 1;
        fstrobe(1); fstrobe(1);
        chk("R8 flag still reports", oof, 1);
        tick();
        chk("R8 no auto pulse", resync, 0);
        tick();
        chk("R8 no auto pulse later", resync, 0);
        sw_req = 1;
        tick();
        chk("R9 manual pulse", resync, 1);
        tick();
        chk("R9 manual ends", resync, 0);
        tick(); tick();
        chk("R9 held request no repeat", resync, 0);
        sw_req = 0;
        realign();
        auto_dis = 0;
        tick();
        chk("R8 enabled without flag", resync, 0);
    endtask

    task automatic t_pin();
        ext_sync_n = 0;
        tick();
        chk("R10 hold asserted", timing_hold, 1);
        tick(); tick();
        chk("R10 hold kept", timing_hold, 1);
        chk("R10 no pulse while low", resync, 0);
        ext_sync_n = 1;
        tick();
        chk("R10 hold released", timing_hold, 0);
        chk("R10 release pulse", resync, 1);
        tick();
        chk("R10 pulse ends", resync, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1;
        tick();
        t_reset();
        t_oof();
        t_carrier();
        t_disable();
        t_pin();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule